// File: doc/BRIEF.md
# Flash Command State Machine

This block is the command front end of a 16-bit NOR-style flash device. Bus write cycles carry a command code in the low byte. That code decides what later bus reads return: array words, the status register, identification words or query words. It also decides when program and erase operations start. A write-state sequencer carries out each operation against a small behavioural word array. The time an operation stays busy is stretched by a run-time busy count. Before an operation starts, the sequencer checks a supply-valid input.

The status register holds sticky error bits. Internal logic can only set them, and only the clear command resets them. While an erase runs, every command except suspend is refused. A suspended erase frees the bus, so the host can read other data. A confirm code then resumes the erase.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the ready output is high and reads return array words without any command being written. A reset does not change the array contents.
- R2: Writing FFh selects array reads and writing 70h selects status reads. The selected mode persists until another command is written. Read data reflects the address presented one clock earlier. Status word layout: bit 7 ready, bit 6 erase suspended, bit 5 erase error, bit 4 program error, bit 3 supply error, all other bits 0.
- R3: After 90h, reads return the maker code at word 0, the device code at word 1, and 0 at every other address.
- R4: After 98h, reads return 0051h, 0052h and 0059h at words 10h, 11h and 12h, and the address width plus one at word 27h. Every other query word reads 0.
- R5: Only bits 7:0 of a command write are decoded. A code that is not recognised leaves the read mode unchanged.
- R6: The sequence 40h, then a data write, stores old AND data at the data write's address. Ready is low for busy_len+3 cycles, and reads then return status.
- R7: The sequence 20h, then D0h, sets every word of the addressed block to FFFFh. Ready is low for block_words+busy_len+1 cycles.
- R8: After 20h, any second byte other than D0h sets bits 4 and 5. The array is not changed and ready stays high.
- R9: If supply-valid is low when a program or erase is requested, bit 3 is set together with bit 4 (program) or bit 5 (erase). The array is not changed and ready stays high.
- R10: Bits 3, 4 and 5 stay set through every other command. Writing 50h clears them and selects array reads.
- R11: While a program is busy, every write is ignored. While an erase is busy and not suspended, every write except B0h is ignored.
- R12: B0h during an erase raises ready and bit 6. While suspended, the mode commands work and array reads are served. D0h resumes the erase, clears bit 6 and lets the erase finish.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Bus write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Word address for reads and writes |
| bus_wdata | input | 16 | Write data; command code on bits 7:0 |
| vpp_ok | input | 1 | Supply valid for program and erase |
| busy_len | input | CNT_W | Extra busy cycles per operation |
| rd_data | output | 16 | Read data, one cycle after address |
| ready | output | 1 | Sequencer ready (status bit 7) |

## Verification
Some behaviours are checked by assertions on every cycle:
- The error bits never drop unless a clear command arrives, and a clear always empties them.
- A request made with a bad supply leaves the sequencer idle.
- Writes refused during a busy erase leave the mode untouched and raise no request.
- A resume only arrives while suspended, and the busy counter counts down one step per cycle.

Other behaviours can only be shown by the bench's scenarios:
- The array contents after AND-programming and block erase.
- The exact number of busy cycles.
- The identification and query sweeps.
- The suspend, read-elsewhere and resume sequence.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [1:0] {
    MODE_ARRAY,
    MODE_STATUS,
    MODE_ID,
    MODE_QUERY
  } rd_mode_e;

  typedef enum logic [1:0] {
    SET_NONE,
    SET_PROG,
    SET_ERASE
  } setup_e;

  typedef enum logic [2:0] {
    W_IDLE,
    W_PRD,
    W_PWR,
    W_ERASE,
    W_WAIT
  } wsm_e;

  localparam logic [7:0] CMD_ARRAY   = 8'hFF;
  localparam logic [7:0] CMD_STATUS  = 8'h70;
  localparam logic [7:0] CMD_IDENT   = 8'h90;
  localparam logic [7:0] CMD_QUERY   = 8'h98;
  localparam logic [7:0] CMD_CLEAR   = 8'h50;
  localparam logic [7:0] CMD_PROG    = 8'h40;
  localparam logic [7:0] CMD_ERASE   = 8'h20;
  localparam logic [7:0] CMD_CONFIRM = 8'hD0;
  localparam logic [7:0] CMD_SUSPEND = 8'hB0;

endpackage

// File: rtl/flash_array_ram.sv
module flash_array_ram #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // single port, read-old-data, synchronous read
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    q <= mem[addr];
  end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  input  logic              prog_running,
  input  logic              erase_running,
  input  logic              suspended,
  output rd_mode_e          mode,
  output logic              prog_req,
  output logic              erase_req,
  output logic              bad_req,
  output logic              clr_req,
  output logic              susp_req,
  output logic              resume_req,
  output logic [ADDR_W-1:0] req_addr,
  output logic [15:0]       req_data
);
  setup_e     setup;
  logic [7:0] code;
  logic       prog_pend;
  logic       erase_pend;

  assign code       = bus_wdata[7:0];
  assign prog_pend  = prog_running || prog_req;
  assign erase_pend = erase_running || erase_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode       <= MODE_ARRAY;
      setup      <= SET_NONE;
      prog_req   <= 1'b0;
      erase_req  <= 1'b0;
      bad_req    <= 1'b0;
      clr_req    <= 1'b0;
      susp_req   <= 1'b0;
      resume_req <= 1'b0;
      req_addr   <= '0;
      req_data   <= '0;
    end else begin
      prog_req   <= 1'b0;
      erase_req  <= 1'b0;
      bad_req    <= 1'b0;
      clr_req    <= 1'b0;
      susp_req   <= 1'b0;
      resume_req <= 1'b0;
      if (bus_we) begin
        if (prog_pend) begin
          // program busy: every write refused
        end else if (erase_pend) begin
          if (code == CMD_SUSPEND) susp_req <= 1'b1;
        end else if (suspended) begin
          unique case (code)
            CMD_ARRAY:   mode <= MODE_ARRAY;
            CMD_STATUS:  mode <= MODE_STATUS;
            CMD_IDENT:   mode <= MODE_ID;
            CMD_QUERY:   mode <= MODE_QUERY;
            CMD_CONFIRM: begin
              resume_req <= 1'b1;
              mode       <= MODE_STATUS;
            end
            default: ;
          endcase
        end else if (setup == SET_PROG) begin
          prog_req <= 1'b1;
          req_addr <= bus_addr;
          req_data <= bus_wdata;
          setup    <= SET_NONE;
          mode     <= MODE_STATUS;
        end else if (setup == SET_ERASE) begin
          if (code == CMD_CONFIRM) erase_req <= 1'b1;
          else                     bad_req   <= 1'b1;
          req_addr <= bus_addr;
          setup    <= SET_NONE;
          mode     <= MODE_STATUS;
        end else begin
          unique case (code)
            CMD_ARRAY:  mode <= MODE_ARRAY;
            CMD_STATUS: mode <= MODE_STATUS;
            CMD_IDENT:  mode <= MODE_ID;
            CMD_QUERY:  mode <= MODE_QUERY;
            CMD_CLEAR: begin
              clr_req <= 1'b1;
              mode    <= MODE_ARRAY;
            end
            CMD_PROG: begin
              setup <= SET_PROG;
              mode  <= MODE_STATUS;
            end
            CMD_ERASE: begin
              setup <= SET_ERASE;
              mode  <= MODE_STATUS;
            end
            default: ;
          endcase
        end
      end
    end
  end

  // R11: a refused write during a running erase changes nothing
  p_erase_lockout_r11: assert property (@(posedge clk) disable iff (rst)
    (bus_we && erase_running && !prog_running && code != CMD_SUSPEND)
      |=> ($stable(mode) && !prog_req && !erase_req && !clr_req && !bad_req));

  // R12: resume can only be issued while the erase is suspended
  p_resume_gated_r12: assert property (@(posedge clk) disable iff (rst)
    resume_req |-> suspended);
endmodule

// File: rtl/flash_wsm.sv
module flash_wsm
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BLK_W  = 4,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              prog_req,
  input  logic              erase_req,
  input  logic              bad_req,
  input  logic              clr_req,
  input  logic              susp_req,
  input  logic              resume_req,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [15:0]       req_data,
  input  logic              vpp_ok,
  input  logic [CNT_W-1:0]  busy_len,
  input  logic [15:0]       ram_q,
  output logic              ram_own,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [15:0]       ram_wdata,
  output logic [7:0]        status,
  output logic              ready,
  output logic              prog_running,
  output logic              erase_running,
  output logic              suspended
);
  localparam logic [BLK_W-1:0] IDX_LAST = '1;

  wsm_e              state;
  logic              erase_op;
  logic              susp;
  logic              sr3, sr4, sr5;
  logic [CNT_W-1:0]  cnt;
  logic [BLK_W-1:0]  idx;
  logic [ADDR_W-1:0] tgt;
  logic [15:0]       pdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= W_IDLE;
      erase_op <= 1'b0;
      susp     <= 1'b0;
      sr3      <= 1'b0;
      sr4      <= 1'b0;
      sr5      <= 1'b0;
      cnt      <= '0;
      idx      <= '0;
      tgt      <= '0;
      pdata    <= '0;
    end else begin
      if (clr_req) begin
        sr3 <= 1'b0;
        sr4 <= 1'b0;
        sr5 <= 1'b0;
      end
      if (bad_req) begin
        sr4 <= 1'b1;
        sr5 <= 1'b1;
      end
      if (prog_req) begin
        if (!vpp_ok) begin
          sr3 <= 1'b1;
          sr4 <= 1'b1;
        end else begin
          state    <= W_PRD;
          erase_op <= 1'b0;
          tgt      <= req_addr;
          pdata    <= req_data;
        end
      end
      if (erase_req) begin
        if (!vpp_ok) begin
          sr3 <= 1'b1;
          sr5 <= 1'b1;
        end else begin
          state    <= W_ERASE;
          erase_op <= 1'b1;
          tgt      <= req_addr;
          idx      <= '0;
        end
      end
      if (susp_req)   susp <= 1'b1;
      if (resume_req) susp <= 1'b0;
      if (!susp) begin
        unique case (state)
          W_PRD: state <= W_PWR;
          W_PWR: begin
            state <= W_WAIT;
            cnt   <= busy_len;
          end
          W_ERASE: begin
            idx <= idx + 1'b1;
            if (idx == IDX_LAST) begin
              state <= W_WAIT;
              cnt   <= busy_len;
            end
          end
          W_WAIT: begin
            if (cnt == '0) state <= W_IDLE;
            else           cnt   <= cnt - 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  assign ram_own       = (state != W_IDLE) && !susp;
  assign ram_we        = ram_own && (state == W_PWR || state == W_ERASE);
  assign ram_addr      = (state == W_ERASE) ? {tgt[ADDR_W-1:BLK_W], idx} : tgt;
  assign ram_wdata     = (state == W_PWR) ? (ram_q & pdata) : 16'hFFFF;
  assign ready         = (state == W_IDLE) || susp;
  assign prog_running  = (state != W_IDLE) && !erase_op;
  assign erase_running = (state != W_IDLE) && erase_op && !susp;
  assign suspended     = susp;
  assign status        = {ready, susp, sr5, sr4, sr3, 3'b000};

  // R10: error bits are sticky until a clear
  p_sticky_sr4_r10: assert property (@(posedge clk) disable iff (rst)
    (sr4 && !clr_req) |=> sr4);
  p_sticky_sr5_r10: assert property (@(posedge clk) disable iff (rst)
    (sr5 && !clr_req) |=> sr5);
  p_clear_r10: assert property (@(posedge clk) disable iff (rst)
    clr_req |=> (!sr3 && !sr4 && !sr5));
  // R9: a request under bad supply never starts the sequencer
  p_vpp_block_r9: assert property (@(posedge clk) disable iff (rst)
    ((prog_req || erase_req) && !vpp_ok) |=> (ready && sr3));
  // R6: busy counter steps down by one per running cycle
  p_wait_count_r6: assert property (@(posedge clk) disable iff (rst)
    (state == W_WAIT && !susp && cnt != '0 && !susp_req)
      |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/flash_read_mux.sv
module flash_read_mux
  import flash_cmd_pkg::*;
#(
  parameter int          ADDR_W = 8,
  parameter logic [15:0] MFR_ID = 16'h00A5,
  parameter logic [15:0] DEV_ID = 16'h5A31
) (
  input  logic              clk,
  input  logic              rst,
  input  rd_mode_e          mode,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        status,
  input  logic [15:0]       ram_q,
  output logic [15:0]       rd_data
);
  localparam logic [15:0] QRY_WIDTH = 16'(ADDR_W + 1);

  rd_mode_e    sel_q;
  logic [15:0] info_q;
  logic [15:0] info_d;
  int unsigned a;

  always_comb begin
    a = 32'(bus_addr);
    info_d = '0;
    unique case (mode)
      MODE_STATUS: info_d = {8'h00, status};
      MODE_ID: begin
        if (a == 0)      info_d = MFR_ID;
        else if (a == 1) info_d = DEV_ID;
      end
      MODE_QUERY: begin
        unique case (a)
          32'h10:  info_d = 16'h0051;
          32'h11:  info_d = 16'h0052;
          32'h12:  info_d = 16'h0059;
          32'h27:  info_d = QRY_WIDTH;
          default: info_d = '0;
        endcase
      end
      default: info_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= MODE_ARRAY;
      info_q <= '0;
    end else begin
      sel_q  <= mode;
      info_q <= info_d;
    end
  end

  assign rd_data = (sel_q == MODE_ARRAY) ? ram_q : info_q;
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int          ADDR_W = 8,
  parameter int          BLK_W  = 4,
  parameter int          CNT_W  = 8,
  parameter logic [15:0] MFR_ID = 16'h00A5,
  parameter logic [15:0] DEV_ID = 16'h5A31
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  input  logic              vpp_ok,
  input  logic [CNT_W-1:0]  busy_len,
  output logic [15:0]       rd_data,
  output logic              ready
);
  rd_mode_e          mode;
  logic              prog_req, erase_req, bad_req, clr_req, susp_req, resume_req;
  logic [ADDR_W-1:0] req_addr;
  logic [15:0]       req_data;
  logic              prog_running, erase_running, suspended;
  logic              ram_own, ram_we;
  logic [ADDR_W-1:0] wsm_addr, ram_addr;
  logic [15:0]       ram_wdata, ram_q;
  logic [7:0]        status;

  flash_cmd_decoder #(.ADDR_W(ADDR_W)) u_dec (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .prog_running(prog_running),
    .erase_running(erase_running), .suspended(suspended), .mode(mode),
    .prog_req(prog_req), .erase_req(erase_req), .bad_req(bad_req),
    .clr_req(clr_req), .susp_req(susp_req), .resume_req(resume_req),
    .req_addr(req_addr), .req_data(req_data)
  );

  flash_wsm #(.ADDR_W(ADDR_W), .BLK_W(BLK_W), .CNT_W(CNT_W)) u_wsm (
    .clk(clk), .rst(rst), .prog_req(prog_req), .erase_req(erase_req),
    .bad_req(bad_req), .clr_req(clr_req), .susp_req(susp_req),
    .resume_req(resume_req), .req_addr(req_addr), .req_data(req_data),
    .vpp_ok(vpp_ok), .busy_len(busy_len), .ram_q(ram_q),
    .ram_own(ram_own), .ram_we(ram_we), .ram_addr(wsm_addr),
    .ram_wdata(ram_wdata), .status(status), .ready(ready),
    .prog_running(prog_running), .erase_running(erase_running),
    .suspended(suspended)
  );

  assign ram_addr = ram_own ? wsm_addr : bus_addr;

  flash_array_ram #(.ADDR_W(ADDR_W), .DATA_W(16)) u_ram (
    .clk(clk), .we(ram_we), .addr(ram_addr), .wdata(ram_wdata), .q(ram_q)
  );

  flash_read_mux #(.ADDR_W(ADDR_W), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) u_rmux (
    .clk(clk), .rst(rst), .mode(mode), .bus_addr(bus_addr),
    .status(status), .ram_q(ram_q), .rd_data(rd_data)
  );
endmodule

// File: tb/flash_cmd_ctrl_bench.sv
`timescale 1ns/1ps
module flash_cmd_ctrl_bench;
  localparam int          AW  = 6;
  localparam int          BW  = 3;
  localparam int          CW  = 8;
  localparam int          NW  = 1 << AW;
  localparam int          BWD = 1 << BW;
  localparam logic [15:0] MFR = 16'h00A5;
  localparam logic [15:0] DEV = 16'h5A31;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [15:0]   bus_wdata = '0;
  logic          vpp_ok = 1'b1;
  logic [CW-1:0] busy_len = '0;
  logic [15:0]   rd_data;
  logic          ready;

  int checks = 0;
  int failures = 0;
  logic [15:0] v;
  int lowc;

  always #2.5 clk = ~clk;

  flash_cmd_ctrl #(.ADDR_W(AW), .BLK_W(BW), .CNT_W(CW), .MFR_ID(MFR), .DEV_ID(DEV))
    u_flash_cmd_ctrl (
      .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .vpp_ok(vpp_ok), .busy_len(busy_len),
      .rd_data(rd_data), .ready(ready)
    );

  function automatic logic [15:0] pat1(int a);
    return 16'(a * 16'h0411) ^ 16'hA5C3;
  endfunction
  function automatic logic [15:0] pat2(int a);
    return 16'(a * 16'h1357) ^ 16'h7E7E;
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [15:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  // counts low-ready cycles of one operation; returns 0 if it never starts
  task automatic run_op(output int low);
    low = 0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (!ready) low++;
      else if (low > 0) break;
      else if (i >= 3) break;
    end
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 ready after reset", {15'd0, ready}, 16'd1);

    wr(0, 16'h0070);
    rd(5, v); chk("R2 status after reset", v, 16'h0080);
    rd(9, v); chk("R2 status mode persists", v, 16'h0080);

    // erase every block
    busy_len = 8'd2;
    for (int b = 0; b < NW / BWD; b++) begin
      wr(AW'(b * BWD), 16'h0020);
      wr(AW'(b * BWD + 1), 16'h00D0);
      run_op(lowc);
      chk("R7 erase busy cycles", 16'(lowc), 16'(BWD + 2 + 1));
    end
    rd(0, v); chk("R7 status after erase", v, 16'h0080);
    wr(0, 16'h00FF);
    for (int a = 0; a < NW; a++) begin
      rd(AW'(a), v); chk("R7 erased word", v, 16'hFFFF);
    end

    // program every word, busy length swept
    for (int a = 0; a < NW; a++) begin
      busy_len = CW'(a % 6);
      wr(AW'(a), 16'h0040);
      wr(AW'(a), pat1(a));
      run_op(lowc);
      chk("R6 program busy cycles", 16'(lowc), 16'(a % 6 + 3));
    end
    rd(3, v); chk("R6 status after program", v, 16'h0080);
    wr(0, 16'h00FF);
    for (int a = 0; a < NW; a++) begin
      rd(AW'(a), v); chk("R2 array read", v, pat1(a));
    end
    busy_len = 8'd1;
    for (int a = 0; a < NW; a++) begin
      wr(AW'(a), 16'h0040);
      wr(AW'(a), pat2(a));
      run_op(lowc);
    end
    wr(0, 16'h00FF);
    for (int a = 0; a < NW; a++) begin
      rd(AW'(a), v); chk("R6 AND programming", v, pat1(a) & pat2(a));
    end

    // identification sweep, upper byte junk
    wr(0, 16'h3790);
    for (int a = 0; a < NW; a++) begin
      rd(AW'(a), v);
      chk("R3 ident word", v, (a == 0) ? MFR : (a == 1) ? DEV : 16'h0000);
    end
    // query sweep
    wr(0, 16'h0098);
    for (int a = 0; a < NW; a++) begin
      rd(AW'(a), v);
      chk("R4 query word", v,
          (a == 16) ? 16'h0051 : (a == 17) ? 16'h0052 :
          (a == 18) ? 16'h0059 : (a == 39) ? 16'(AW + 1) : 16'h0000);
    end
    // low byte only; unknown code ignored
    wr(0, 16'hFF70);
    rd(1, v); chk("R5 high byte ignored", v, 16'h0080);
    wr(0, 16'h0012);
    rd(1, v); chk("R5 unknown code no effect", v, 16'h0080);

    // bad confirm
    wr(8, 16'h0020);
    wr(8, 16'h00FF);
    run_op(lowc);
    chk("R8 ready stays high", 16'(lowc), 16'd0);
    rd(8, v); chk("R8 status bits", v, 16'h00B0);
    wr(0, 16'h00FF);
    rd(8, v); chk("R8 array untouched", v, pat1(8) & pat2(8));

    // sticky bits
    wr(0, 16'h0090);
    wr(0, 16'h0070);
    rd(0, v); chk("R10 bits stay set", v, 16'h00B0);
    wr(0, 16'h0050);
    rd(8, v); chk("R10 clear returns array", v, pat1(8) & pat2(8));
    wr(0, 16'h0070);
    rd(0, v); chk("R10 bits cleared", v, 16'h0080);

    // supply invalid
    vpp_ok = 1'b0;
    wr(9, 16'h0040);
    wr(9, 16'h0000);
    run_op(lowc);
    chk("R9 program ready high", 16'(lowc), 16'd0);
    rd(9, v); chk("R9 program supply status", v, 16'h0098);
    wr(0, 16'h0050);
    rd(9, v); chk("R9 program array untouched", v, pat1(9) & pat2(9));
    wr(16, 16'h0020);
    wr(16, 16'h00D0);
    run_op(lowc);
    chk("R9 erase ready high", 16'(lowc), 16'd0);
    rd(16, v); chk("R9 erase supply status", v, 16'h00A8);
    wr(0, 16'h0050);
    rd(17, v); chk("R9 erase array untouched", v, pat1(17) & pat2(17));
    vpp_ok = 1'b1;

    // program busy lockout
    busy_len = 8'd20;
    wr(10, 16'h0040);
    wr(10, 16'h0000);
    wr(0, 16'h00FF);
    wr(0, 16'h0090);
    for (int i = 0; i < 100 && !ready; i++) @(negedge clk);
    rd(0, v); chk("R11 program lockout keeps status mode", v, 16'h0080);
    wr(0, 16'h00FF);
    rd(10, v); chk("R6 programmed zero", v, 16'h0000);

    // erase lockout, suspend, resume
    busy_len = 8'd40;
    wr(24, 16'h0020);
    wr(24, 16'h00D0);
    repeat (3) @(negedge clk);
    wr(0, 16'h00FF);
    rd(0, v); chk("R11 erase lockout", v, 16'h0000);
    wr(0, 16'h00B0);
    repeat (2) @(negedge clk);
    chk("R12 ready while suspended", {15'd0, ready}, 16'd1);
    rd(0, v); chk("R12 suspend status", v, 16'h00C0);
    wr(0, 16'h00FF);
    rd(0, v); chk("R12 array read while suspended", v, pat1(0) & pat2(0));
    wr(24, 16'h00D0);
    rd(0, v); chk("R12 resumed busy status", v, 16'h0000);
    for (int i = 0; i < 200 && !ready; i++) @(negedge clk);
    rd(0, v); chk("R12 done status", v, 16'h0080);
    wr(0, 16'h00FF);
    for (int a = 24; a < 32; a++) begin
      rd(AW'(a), v); chk("R12 block erased after resume", v, 16'hFFFF);
    end
    rd(32, v); chk("R12 neighbour block intact", v, pat1(32) & pat2(32));

    // reset keeps array, returns to array reads
    wr(0, 16'h0070);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    rd(0, v); chk("R1 array mode after reset", v, pat1(0) & pat2(0));
    chk("R1 ready after second reset", {15'd0, ready}, 16'd1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule